// File: doc/BRIEF.md
# Eight-Channel Conversion Result and Interrupt Register Bank

This block sits between an analog-to-digital converter's channel sequencer and the software-visible register space. Each time the sequencer reports a finished conversion (a one-cycle completion strobe with a 3-bit channel number and a 10-bit result), the block stores the result in that channel's data word and raises the channel's done flag. It also keeps a global word that always holds the most recent result, together with the number of the channel that produced it.

In burst mode the sequencer converts without pause, so a result may arrive before software has collected the previous one on the same channel. The block records that loss in an overrun flag. Reading a data word clears its done and overrun flags. A per-channel interrupt-enable mask selects which channels drive the interrupt line. A separate enable bit selects whether the global done flag also drives it; that bit is meant to be cleared in burst mode and has no effect while burst mode is active.

Software reaches the bank through a simple single-cycle read/write port. Read data is a combinational function of the address and the stored state. Flags are cleared at the clock edge that ends the read cycle.

Top module: `adc_result_bank`

## Requirements
- R1: Word addresses are fixed as follows: 0 is the global data word, 1 is the interrupt-enable word, and 2+n is the data word of channel n (n = 0..7). Every other address reads as zero. Writes have an effect only at address 1.
- R2: A channel data word holds the 10-bit result in bits 15:6, overrun in bit 30 and done in bit 31. Bits 5:0 and 29:16 read as zero.
- R3: A completion strobe for channel n stores the result in channel n and sets its done flag. The new value is visible from the cycle after the strobe.
- R4: Reading channel n's data word clears that channel's done and overrun flags at the end of the read cycle. Every other channel's flags stay unchanged.
- R5: In burst mode, a completion on a channel whose done flag is still set (and is not being read in the same cycle) sets that channel's overrun flag. Outside burst mode, overrun is never newly set.
- R6: The interrupt-enable word resets to 0x100. Bits 8:0 are writable, and bits 31:9 read as zero.
- R7: The interrupt output is a level signal. It is the OR over n of (done of channel n AND enable bit n), ORed with (global done AND enable bit 8 AND NOT burst mode). It falls once the flags causing it are read.
- R8: The global word holds the latest result in bits 15:6, its channel number in bits 26:24, overrun in bit 30 and done in bit 31. Every completion sets global done. In burst mode, a completion while global done is still set sets global overrun. Reading the global word clears only the global flags.
- R9: When a completion and a read of the same data word fall in one cycle, the read returns the old contents. Afterwards the word holds the new result, and its done flag stays set.
- R10: While burst mode is active, enable bit 8 has no effect on the interrupt output.
- R11: The extreme results 0x000 and 0x3FF are stored and read back unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid | input | 1 | One-cycle conversion-complete strobe |
| conv_chan | input | 3 | Channel number of the finished conversion |
| conv_result | input | 10 | Conversion result |
| burst_mode | input | 1 | Sequencer is converting continuously |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags of the addressed word) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Conversion-complete interrupt (level) |

## Verification
The checker covers the rules that hold cycle by cycle:
- a strobe sets the addressed done flag on the next cycle;
- a read clears that channel's flags unless a completion collides with it;
- overrun never rises outside burst mode;
- reserved bits read as zero;
- the interrupt only rises with an enabled flag behind it, and stays low in burst mode unless an enabled channel is done;
- a global read leaves the channel flags alone.

Only the bench's scenarios can show the actual data values returned after particular histories. These include the overrun flag after back-to-back burst conversions, the old-then-new sequence of a read that collides with a strobe, the extreme codes, ignored writes and unmapped reads, and the interrupt falling as flags are collected.

// File: rtl/adc_bank_pkg.sv
package adc_bank_pkg;
    // field positions inside a data word
    localparam int unsigned RES_LSB      = 6;
    localparam int unsigned CHAN_LSB     = 24;
    localparam int unsigned OVR_BIT      = 30;
    localparam int unsigned DONE_BIT     = 31;
    // word addresses
    localparam int unsigned ADDR_GLOBAL  = 0;
    localparam int unsigned ADDR_IEN     = 1;
    localparam int unsigned ADDR_CH_BASE = 2;
endpackage

// File: rtl/adc_result_slot.sv
module adc_result_slot #(
    parameter int unsigned RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RES_W-1:0] load_val,
    input  logic             burst,
    input  logic             rd_clear,
    output logic [RES_W-1:0] res_q,
    output logic             done_q,
    output logic             ovr_q
);
    typedef struct packed {
        logic [RES_W-1:0] res;
        logic             done;
        logic             ovr;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            // a new completion wins over a read in the same cycle
            st_d.res  = load_val;
            st_d.done = 1'b1;
            st_d.ovr  = !rd_clear && (st_q.ovr || (burst && st_q.done));
        end else if (rd_clear) begin
            st_d.done = 1'b0;
            st_d.ovr  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q  = st_q.res;
    assign done_q = st_q.done;
    assign ovr_q  = st_q.ovr;
endmodule

// File: rtl/adc_irq_merge.sv
module adc_irq_merge #(
    parameter int unsigned NUM_CH = 8
) (
    input  logic [NUM_CH-1:0] ch_done,
    input  logic [NUM_CH:0]   ien,
    input  logic              g_done,
    input  logic              burst,
    output logic              irq
);
    logic ch_hit;
    logic g_hit;

    always_comb begin
        ch_hit = |(ch_done & ien[NUM_CH-1:0]);
        // the global source is gated off while converting continuously
        g_hit  = g_done && ien[NUM_CH] && !burst;
        irq    = ch_hit || g_hit;
    end
endmodule

// File: rtl/adc_read_mux.sv
module adc_read_mux
    import adc_bank_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned RES_W  = 10,
    parameter int unsigned CH_W   = 3,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [NUM_CH-1:0][RES_W-1:0]  ch_res,
    input  logic [NUM_CH-1:0]             ch_done,
    input  logic [NUM_CH-1:0]             ch_ovr,
    input  logic [RES_W-1:0]              g_res,
    input  logic                          g_done,
    input  logic                          g_ovr,
    input  logic [CH_W-1:0]               g_chan,
    input  logic [NUM_CH:0]               ien,
    output logic [DATA_W-1:0]             rdata
);
    function automatic logic [DATA_W-1:0] pack_word(
        input logic [RES_W-1:0] res,
        input logic             done,
        input logic             ovr
    );
        logic [DATA_W-1:0] w;
        w                    = '0;
        w[RES_LSB +: RES_W]  = res;
        w[OVR_BIT]           = ovr;
        w[DONE_BIT]          = done;
        return w;
    endfunction

    always_comb begin
        rdata = '0;
        if (rd_addr == ADDR_W'(ADDR_GLOBAL)) begin
            rdata                   = pack_word(g_res, g_done, g_ovr);
            rdata[CHAN_LSB +: CH_W] = g_chan;
        end else if (rd_addr == ADDR_W'(ADDR_IEN)) begin
            rdata[NUM_CH:0] = ien;
        end
        for (int k = 0; k < NUM_CH; k++) begin
            if (rd_addr == ADDR_W'(ADDR_CH_BASE + k)) begin
                rdata = pack_word(ch_res[k], ch_done[k], ch_ovr[k]);
            end
        end
    end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_bank_pkg::*;
#(
    parameter  int unsigned NUM_CH = 8,
    parameter  int unsigned RES_W  = 10,
    parameter  int unsigned ADDR_W = 4,
    parameter  int unsigned DATA_W = 32,
    localparam int unsigned CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid,
    input  logic [CH_W-1:0]   conv_chan,
    input  logic [RES_W-1:0]  conv_result,
    input  logic              burst_mode,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam logic [NUM_CH:0] IEN_RESET = {1'b1, {NUM_CH{1'b0}}};

    typedef struct packed {
        logic [NUM_CH:0] ien;
        logic [CH_W-1:0] g_chan;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [NUM_CH-1:0][RES_W-1:0] ch_res;
    logic [NUM_CH-1:0]            ch_done;
    logic [NUM_CH-1:0]            ch_ovr;
    logic [NUM_CH-1:0]            ch_load;
    logic [NUM_CH-1:0]            ch_rd;
    logic [RES_W-1:0]             g_res;
    logic                         g_done;
    logic                         g_ovr;
    logic                         g_rd;
    logic [NUM_CH:0]              ien_q;
    logic                         unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:NUM_CH+1];

    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_wr && reg_addr == ADDR_W'(ADDR_IEN)) begin
            ctrl_d.ien = reg_wdata[NUM_CH:0];
        end
        if (conv_valid) begin
            ctrl_d.g_chan = conv_chan;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{ien: IEN_RESET, g_chan: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ien_q = ctrl_q.ien;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_slot
        assign ch_load[k] = conv_valid && (conv_chan == CH_W'(k));
        assign ch_rd[k]   = reg_rd && (reg_addr == ADDR_W'(ADDR_CH_BASE + k));

        adc_result_slot #(.RES_W(RES_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ch_load[k]),
            .load_val (conv_result),
            .burst    (burst_mode),
            .rd_clear (ch_rd[k]),
            .res_q    (ch_res[k]),
            .done_q   (ch_done[k]),
            .ovr_q    (ch_ovr[k])
        );
    end

    assign g_rd = reg_rd && (reg_addr == ADDR_W'(ADDR_GLOBAL));

    adc_result_slot #(.RES_W(RES_W)) u_global (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (conv_valid),
        .load_val (conv_result),
        .burst    (burst_mode),
        .rd_clear (g_rd),
        .res_q    (g_res),
        .done_q   (g_done),
        .ovr_q    (g_ovr)
    );

    adc_irq_merge #(.NUM_CH(NUM_CH)) u_irq (
        .ch_done (ch_done),
        .ien     (ien_q),
        .g_done  (g_done),
        .burst   (burst_mode),
        .irq     (irq)
    );

    adc_read_mux #(
        .NUM_CH (NUM_CH),
        .RES_W  (RES_W),
        .CH_W   (CH_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rmux (
        .rd_addr (reg_addr),
        .ch_res  (ch_res),
        .ch_done (ch_done),
        .ch_ovr  (ch_ovr),
        .g_res   (g_res),
        .g_done  (g_done),
        .g_ovr   (g_ovr),
        .g_chan  (ctrl_q.g_chan),
        .ien     (ien_q),
        .rdata   (reg_rdata)
    );
endmodule

// File: rtl/adc_result_bank_chk.sv
module adc_result_bank_chk
    import adc_bank_pkg::*;
#(
    parameter  int unsigned NUM_CH = 8,
    parameter  int unsigned RES_W  = 10,
    parameter  int unsigned ADDR_W = 4,
    parameter  int unsigned DATA_W = 32,
    localparam int unsigned CH_W   = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_valid,
    input logic [CH_W-1:0]   conv_chan,
    input logic              burst_mode,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic [NUM_CH-1:0] ch_done,
    input logic [NUM_CH-1:0] ch_ovr,
    input logic              g_done,
    input logic [NUM_CH:0]   ien
);
    // R3 and R9: a strobe always leaves the addressed done flag set
    p_done_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |=> ch_done[$past(conv_chan)])
        else $error("p_done_set_r3");

    // R5
    p_no_idle_ovr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_mode |=> ((ch_ovr & ~$past(ch_ovr)) == '0))
        else $error("p_no_idle_ovr_r5");

    // R6
    p_ien_rsv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(ADDR_IEN)) |-> (reg_rdata[DATA_W-1:NUM_CH+1] == '0))
        else $error("p_ien_rsv_r6");

    // R7
    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((|(ch_done & ien[NUM_CH-1:0])) || (g_done && ien[NUM_CH])))
        else $error("p_irq_source_r7");

    // R10
    p_burst_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_mode && ((ch_done & ien[NUM_CH-1:0]) == '0)) |-> !irq)
        else $error("p_burst_gate_r10");

    // R8
    p_glb_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(ADDR_GLOBAL) && !conv_valid)
            |=> (ch_done == $past(ch_done)))
        else $error("p_glb_keep_r8");

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
        // R4
        p_rd_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && reg_addr == ADDR_W'(ADDR_CH_BASE + k)
                && !(conv_valid && conv_chan == CH_W'(k)))
                |=> (!ch_done[k] && !ch_ovr[k]))
            else $error("p_rd_clear_r4");

        // R2
        p_data_rsv_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr == ADDR_W'(ADDR_CH_BASE + k))
                |-> (reg_rdata[RES_LSB-1:0] == '0
                     && reg_rdata[OVR_BIT-1:RES_LSB+RES_W] == '0))
            else $error("p_data_rsv_r2");
    end
endmodule

bind adc_result_bank adc_result_bank_chk #(
    .NUM_CH (NUM_CH),
    .RES_W  (RES_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_valid (conv_valid),
    .conv_chan  (conv_chan),
    .burst_mode (burst_mode),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .irq        (irq),
    .ch_done    (ch_done),
    .ch_ovr     (ch_ovr),
    .g_done     (g_done),
    .ien        (ien_q)
);

// File: tb/adc_result_bank_test.sv
module adc_result_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_valid = 1'b0;
    logic [2:0]  conv_chan = '0;
    logic [9:0]  conv_result = '0;
    logic        burst_mode = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_result_bank uut (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_chan(conv_chan),
        .conv_result(conv_result), .burst_mode(burst_mode), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // reference model, built from the requirements
    logic       m_done [8];
    logic       m_ovr  [8];
    logic [9:0] m_res  [8];
    logic       m_gdone, m_govr;
    logic [9:0] m_gres;
    logic [2:0] m_gch;
    logic [8:0] m_ien;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    item_t mon_it;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input logic [9:0] r, input logic d, input logic o);
        logic [31:0] w;
        w = '0;
        w[15:6] = r;
        w[30] = o;
        w[31] = d;
        return w;
    endfunction

    function automatic logic [31:0] model_word(input logic [3:0] a);
        logic [31:0] w;
        w = '0;
        if (a == 4'd0) begin
            w = word(m_gres, m_gdone, m_govr);
            w[26:24] = m_gch;
        end else if (a == 4'd1) begin
            w[8:0] = m_ien;
        end else if (a >= 4'd2 && a <= 4'd9) begin
            w = word(m_res[a-2], m_done[a-2], m_ovr[a-2]);
        end
        return w;
    endfunction

    function automatic logic model_irq();
        logic x;
        x = m_gdone && m_ien[8] && !burst_mode;
        for (int k = 0; k < 8; k++) x = x | (m_done[k] & m_ien[k]);
        return x;
    endfunction

    // monitor: compares read data in the middle of the read cycle
    always @(negedge clk) begin
        #2;
        if (reg_rd) begin
            if (sb_q.size() == 0) begin
                check("scoreboard underflow", 32'd1, 32'd0);
            end else begin
                mon_it = sb_q.pop_front();
                check(mon_it.tag, reg_rdata, mon_it.exp);
            end
        end
    end

    task automatic step(input logic cv, input logic [2:0] ch, input logic [9:0] res,
                        input logic rd, input logic [3:0] addr, input string tag);
        item_t it;
        @(negedge clk);
        conv_valid = cv; conv_chan = ch; conv_result = res;
        reg_rd = rd; reg_addr = addr; reg_wr = 1'b0; reg_wdata = '0;
        if (rd) begin
            it.exp = model_word(addr);
            it.tag = tag;
            sb_q.push_back(it);
        end
        for (int k = 0; k < 8; k++) begin
            logic hit, rk;
            hit = cv && (ch == 3'(k));
            rk  = rd && (addr == 4'(k + 2));
            if (hit) begin
                m_ovr[k]  = !rk && (m_ovr[k] || (burst_mode && m_done[k]));
                m_done[k] = 1'b1;
                m_res[k]  = res;
            end else if (rk) begin
                m_done[k] = 1'b0;
                m_ovr[k]  = 1'b0;
            end
        end
        if (cv) begin
            m_govr  = !(rd && addr == 4'd0) && (m_govr || (burst_mode && m_gdone));
            m_gdone = 1'b1;
            m_gres  = res;
            m_gch   = ch;
        end else if (rd && addr == 4'd0) begin
            m_gdone = 1'b0;
            m_govr  = 1'b0;
        end
    endtask

    task automatic conv(input logic [2:0] ch, input logic [9:0] res);
        step(1'b1, ch, res, 1'b0, 4'd0, "");
    endtask

    task automatic rd(input logic [3:0] addr, input string tag);
        step(1'b0, 3'd0, 10'd0, 1'b1, addr, tag);
    endtask

    task automatic wr(input logic [3:0] addr, input logic [31:0] data);
        @(negedge clk);
        conv_valid = 1'b0; reg_rd = 1'b0;
        reg_wr = 1'b1; reg_addr = addr; reg_wdata = data;
        if (addr == 4'd1) m_ien = data[8:0];
    endtask

    task automatic irq_chk(input string tag);
        @(negedge clk);
        conv_valid = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0;
        #3;
        check(tag, {31'd0, irq}, {31'd0, model_irq()});
    endtask

    task automatic set_burst(input logic b);
        @(negedge clk);
        conv_valid = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0;
        burst_mode = b;
    endtask

    initial begin
        #800000;
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) begin
            m_done[k] = 1'b0; m_ovr[k] = 1'b0; m_res[k] = '0;
        end
        m_gdone = 1'b0; m_govr = 1'b0; m_gres = '0; m_gch = '0; m_ien = 9'h100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(4'd1, "R6 reset enable word");
        rd(4'd2, "R2 reset channel word");
        irq_chk("R7 reset irq low");

        // basic completion, global enable on by default
        conv(3'd3, 10'h155);
        irq_chk("R7 global done drives irq");
        rd(4'd5, "R3 channel 3 result and done");
        rd(4'd0, "R8 global word after channel 3");
        rd(4'd5, "R4 done cleared by read");
        irq_chk("R7 irq falls after reads");

        // per-channel enables, global off
        wr(4'd1, 32'h0000_000A);
        rd(4'd1, "R6 enable word readback");
        conv(3'd2, 10'h0F0);
        irq_chk("R7 disabled channel no irq");
        conv(3'd1, 10'h101);
        irq_chk("R7 enabled channel irq");
        rd(4'd7, "R4 unrelated read");
        irq_chk("R4 other channel flag untouched");
        rd(4'd0, "R8 global read keeps channels");
        irq_chk("R8 channel 1 still pending");
        rd(4'd3, "R4 read channel 1");
        irq_chk("R7 irq falls after channel read");
        rd(4'd4, "R3 channel 2 retained");

        // non-burst back-to-back: no overrun
        conv(3'd4, 10'h011);
        conv(3'd4, 10'h022);
        rd(4'd6, "R5 no overrun outside burst");
        rd(4'd0, "R8 no global overrun outside burst");

        // burst overrun
        set_burst(1'b1);
        conv(3'd4, 10'h033);
        conv(3'd4, 10'h044);
        rd(4'd6, "R5 burst overrun set");
        rd(4'd6, "R4 overrun and done cleared");
        rd(4'd0, "R8 global overrun set");
        rd(4'd0, "R8 global flags cleared");

        // burst: global enable ignored
        wr(4'd1, 32'h0000_0100);
        conv(3'd0, 10'h077);
        irq_chk("R10 global enable ignored in burst");
        set_burst(1'b0);
        irq_chk("R10 global enable active outside burst");
        rd(4'd0, "R8 clear global");
        rd(4'd2, "R3 clear channel 0");

        // collisions
        conv(3'd6, 10'h1AA);
        step(1'b1, 3'd6, 10'h2BB, 1'b1, 4'd8, "R9 collision returns old word");
        rd(4'd8, "R9 new result kept with done");
        step(1'b1, 3'd5, 10'h0CC, 1'b1, 4'd0, "R9 global collision returns old");
        rd(4'd0, "R9 global keeps new result");
        rd(4'd7, "R9 clear channel 5");

        // extremes
        conv(3'd7, 10'h3FF);
        conv(3'd0, 10'h000);
        rd(4'd9, "R11 full-scale code");
        rd(4'd2, "R11 zero code");

        // map: ignored writes, unmapped reads, reserved enable bits
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd4, "R1 write to data word ignored");
        wr(4'd15, 32'hFFFF_FFFF);
        rd(4'd15, "R1 unmapped address reads zero");
        rd(4'd1, "R1 enable unchanged by other writes");
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd1, "R6 reserved enable bits read zero");

        @(negedge clk);
        conv_valid = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        if (sb_q.size() != 0) check("scoreboard leftover", 32'(sb_q.size()), 32'd0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule